// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by reading two levels of translation entries from memory. It starts from a directory base address supplied by the surrounding logic. The virtual address is split three ways. The upper ten bits pick a directory entry. The next ten bits pick an entry inside the second-level table that the directory entry points to. The low twelve bits pass straight through as the byte offset within the page. A directory entry can also describe a 4 MB page on its own. In that case the second-level read is skipped, and the low 22 address bits pass through.

Each request carries a write flag and a user-mode flag. The walker checks presence and permission at every level it visits. It then returns one of two results:
- a physical address, together with the low attribute bits of the leaf entry;
- a fault report, giving the cause, the address, the access type and the mode.

When a translation succeeds, the walker sets the accessed flag in each entry it used. On a write it also sets the dirty flag in the leaf entry. These flags go back to memory through the same word port, and only for entries whose value actually changes.

Top module: `vm_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req` and `rsp_valid` are 0.
- R2: The directory entry is read at `dir_base + 4*va[31:22]`. When that entry is present and bit 7 is 0, the second-level entry is read at `{pde[31:12],12'h000} + 4*va[21:12]`.
- R3: If a translation through two levels succeeds, `rsp_paddr` is `{pte[31:12], va[11:0]}` and `rsp_fault` is 0.
- R4: If bit 0 (present) of the entry at either level is 0, the result is a fault with `rsp_cause` = 0 (absent). No further entry is read, and no memory write occurs.
- R5: An access faults with `rsp_cause` = 1 (protection) in two cases: a write where bit 1 (writable) is 0 in any visited entry, or a user access where bit 2 (user) is 0 in any visited entry.
- R6: An absent second-level entry reports cause 0, even when the directory entry would also deny the access.
- R7: Every result echoes the request's virtual address, write flag and user flag. On a fault, `rsp_paddr` and `rsp_attr` are 0.
- R8: On success, bit 5 (accessed) is set in memory in every visited entry. On a write, bit 6 (dirty) is also set in the leaf entry. `rsp_attr` shows the leaf entry's bits 11:0 after this update.
- R9: An entry is written back only if its flag update changes it. The directory entry is written before the second-level entry. A faulting walk writes nothing.
- R10: If a present directory entry has bit 7 set, it is the leaf. Then `rsp_paddr` is `{pde[31:22], va[21:0]}`, and exactly one memory read occurs.
- R11: Once `mem_req` is raised, it stays high with a stable address, write enable and write data until `mem_ack` is seen.
- R12: `rsp_valid` is a single-cycle pulse. `req_ready` is high only while the walker is idle, and no memory request is made in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_base | input | 32 | Byte address of the directory, sampled with each request |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry word |
| mem_wdata | output | 32 | Updated entry for a write-back |
| mem_ack | input | 1 | Memory accepts the access this cycle; read data valid |
| mem_rdata | input | 32 | Entry word read from memory |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Result is a page fault |
| rsp_cause | output | 1 | Fault cause: 0 absent, 1 protection |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_attr | output | 12 | Leaf entry bits 11:0 after the flag update (0 on a fault) |
| rsp_vaddr | output | 32 | Virtual address of the walk |
| rsp_write | output | 1 | Write flag of the walk |
| rsp_user | output | 1 | User flag of the walk |

## Verification
A stale or wrongly sequenced walk state shows at the ports in one of two ways:
- a memory read at the wrong entry address, which surfaces as a wrong physical address in the same walk;
- a missing or extra write-back, which the bench sees in its per-walk count of memory writes and in the entry words it holds.

A wrong decision between fault and success, or between the two fault causes, appears in the very next result pulse, which is compared field by field. Any breach of the handshake rule is caught in the cycle after the stall. The same holds for a response pulse that lasts too long, or a request made while idle.

// File: rtl/vm_walk_pkg.sv
// Package: shared state encoding and entry bit positions for the page walker.
// Assumes 32-bit entries whose flag bits sit below the 4 KB frame field.
package vm_walk_pkg;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITABLE = 1;
    localparam int BIT_USER = 2;
    localparam int BIT_ACCESSED = 5;
    localparam int BIT_DIRTY = 6;
    localparam int BIT_BIGPAGE = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_CHK_DIR,
        ST_RD_TBL,
        ST_CHK_TBL,
        ST_WB_DIR,
        ST_WB_TBL,
        ST_RESP
    } walk_state_e;

    localparam logic CAUSE_ABSENT = 1'b0;
    localparam logic CAUSE_PROT = 1'b1;

endpackage

// File: rtl/vm_walk_addr.sv
// Module: address arithmetic for the walk. Forms both entry addresses and
// both candidate physical addresses from the captured request and entries.
// Purely combinational; assumes DIR_IDX_W + TBL_IDX_W < ADDR_W - 2.
module vm_walk_addr #(
    parameter int ADDR_W = 32,
    parameter int DIR_IDX_W = 10,
    parameter int TBL_IDX_W = 10
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic [ADDR_W-1:DIR_IDX_W*0+ADDR_W-DIR_IDX_W-TBL_IDX_W] pde_frame,
    input  logic [ADDR_W-1:ADDR_W-DIR_IDX_W-TBL_IDX_W] pte_frame,
    output logic [ADDR_W-1:0] pde_addr,
    output logic [ADDR_W-1:0] pte_addr,
    output logic [ADDR_W-1:0] paddr_small,
    output logic [ADDR_W-1:0] paddr_large
);
    localparam int OFF_W = ADDR_W - DIR_IDX_W - TBL_IDX_W;
    localparam int BIG_OFF_W = OFF_W + TBL_IDX_W;

    logic [DIR_IDX_W-1:0] dir_idx;
    logic [TBL_IDX_W-1:0] tbl_idx;

    // Split the virtual address into its two indices.
    always_comb begin
        dir_idx = vaddr[ADDR_W-1 -: DIR_IDX_W];
        tbl_idx = vaddr[OFF_W +: TBL_IDX_W];
    end

    // Entry addresses: base plus a word-scaled index.
    always_comb begin
        pde_addr = dir_base + {{(ADDR_W-DIR_IDX_W-2){1'b0}}, dir_idx, 2'b00};
        pte_addr = {pde_frame, {OFF_W{1'b0}}}
                 + {{(ADDR_W-TBL_IDX_W-2){1'b0}}, tbl_idx, 2'b00};
    end

    // Physical addresses for a small page and for a directory-level page.
    always_comb begin
        paddr_small = {pte_frame, vaddr[OFF_W-1:0]};
        paddr_large = {pde_frame[ADDR_W-1:BIG_OFF_W], vaddr[BIG_OFF_W-1:0]};
    end

endmodule

// File: rtl/vm_walk_perm.sv
// Module: per-entry evaluation. Reports presence, whether the access is
// permitted by this entry, and the entry with its usage flags applied.
// Combinational; one instance per table level.
module vm_walk_perm #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] entry,
    input  logic              is_write,
    input  logic              is_user,
    input  logic              set_dirty,
    output logic              present,
    output logic              allow,
    output logic              changed,
    output logic [ADDR_W-1:0] updated
);
    import vm_walk_pkg::*;

    // Presence and permission of this entry for the requested access.
    always_comb begin
        present = entry[BIT_PRESENT];
        allow = (!is_write || entry[BIT_WRITABLE]) && (!is_user || entry[BIT_USER]);
    end

    // Apply the accessed flag and, when asked, the dirty flag.
    always_comb begin
        updated = entry;
        updated[BIT_ACCESSED] = 1'b1;
        if (set_dirty) begin
            updated[BIT_DIRTY] = 1'b1;
        end
        changed = (updated != entry);
    end

endmodule

// File: rtl/vm_walk_seq.sv
// Module: walk sequencer. Accepts a request, drives the memory port for
// entry reads and write-backs, decides fault or success, and holds the
// result for one pulse. Assumes memory holds each access until mem_ack.
module vm_walk_seq #(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              req_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] pde_addr,
    input  logic [ADDR_W-1:0] pte_addr,
    input  logic [ADDR_W-1:0] paddr_small,
    input  logic [ADDR_W-1:0] paddr_large,
    input  logic              dir_present,
    input  logic              dir_allow,
    input  logic              dir_changed,
    input  logic [ADDR_W-1:0] dir_updated,
    input  logic              tbl_present,
    input  logic              tbl_allow,
    input  logic              tbl_changed,
    input  logic [ADDR_W-1:0] tbl_updated,
    output logic [ADDR_W-1:0] pde_q,
    output logic [ADDR_W-1:0] pte_q,
    output logic [ADDR_W-1:0] va_q,
    output logic              wr_q,
    output logic              usr_q,
    output logic [ADDR_W-1:0] base_q,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_cause,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [ATTR_W-1:0] rsp_attr
);
    import vm_walk_pkg::*;

    walk_state_e state_q, state_d;
    logic        leaf_big;

    assign leaf_big = pde_q[BIT_BIGPAGE];

    // Next-state selection for the walk.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_RD_DIR;
            ST_RD_DIR:  if (mem_ack) state_d = ST_CHK_DIR;
            ST_CHK_DIR: begin
                if (!dir_present) begin
                    state_d = ST_RESP;
                end else if (leaf_big) begin
                    state_d = (dir_allow && dir_changed) ? ST_WB_DIR : ST_RESP;
                end else begin
                    state_d = ST_RD_TBL;
                end
            end
            ST_RD_TBL:  if (mem_ack) state_d = ST_CHK_TBL;
            ST_CHK_TBL: begin
                if (!tbl_present || !(dir_allow && tbl_allow)) begin
                    state_d = ST_RESP;
                end else if (dir_changed) begin
                    state_d = ST_WB_DIR;
                end else if (tbl_changed) begin
                    state_d = ST_WB_TBL;
                end else begin
                    state_d = ST_RESP;
                end
            end
            ST_WB_DIR: begin
                if (mem_ack) begin
                    state_d = (!leaf_big && tbl_changed) ? ST_WB_TBL : ST_RESP;
                end
            end
            ST_WB_TBL:  if (mem_ack) state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Memory port driven from the current state only, so it holds steady.
    always_comb begin
        mem_req = (state_q == ST_RD_DIR) || (state_q == ST_RD_TBL)
               || (state_q == ST_WB_DIR) || (state_q == ST_WB_TBL);
        mem_we = (state_q == ST_WB_DIR) || (state_q == ST_WB_TBL);
        mem_addr = ((state_q == ST_RD_DIR) || (state_q == ST_WB_DIR)) ? pde_addr : pte_addr;
        mem_wdata = (state_q == ST_WB_DIR) ? dir_updated : tbl_updated;
    end

    // Handshake outputs.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
    end

    // Request capture, entry capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q <= '0;
            wr_q <= 1'b0;
            usr_q <= 1'b0;
            base_q <= '0;
            pde_q <= '0;
            pte_q <= '0;
            rsp_fault <= 1'b0;
            rsp_cause <= CAUSE_ABSENT;
            rsp_paddr <= '0;
            rsp_attr <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q <= req_vaddr;
                        wr_q <= req_write;
                        usr_q <= req_user;
                        base_q <= dir_base;
                        rsp_fault <= 1'b0;
                        rsp_cause <= CAUSE_ABSENT;
                        rsp_paddr <= '0;
                        rsp_attr <= '0;
                    end
                end
                ST_RD_DIR: if (mem_ack) pde_q <= mem_rdata;
                ST_CHK_DIR: begin
                    if (!dir_present) begin
                        rsp_fault <= 1'b1;
                        rsp_cause <= CAUSE_ABSENT;
                    end else if (leaf_big) begin
                        if (!dir_allow) begin
                            rsp_fault <= 1'b1;
                            rsp_cause <= CAUSE_PROT;
                        end else begin
                            rsp_paddr <= paddr_large;
                            rsp_attr <= dir_updated[ATTR_W-1:0];
                        end
                    end
                end
                ST_RD_TBL: if (mem_ack) pte_q <= mem_rdata;
                ST_CHK_TBL: begin
                    if (!tbl_present) begin
                        rsp_fault <= 1'b1;
                        rsp_cause <= CAUSE_ABSENT;
                    end else if (!(dir_allow && tbl_allow)) begin
                        rsp_fault <= 1'b1;
                        rsp_cause <= CAUSE_PROT;
                    end else begin
                        rsp_paddr <= paddr_small;
                        rsp_attr <= tbl_updated[ATTR_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vm_walker.sv
// Module: top of the two-level page walker. Wires the sequencer, the
// address arithmetic and one entry evaluator per level.
// Assumes a word memory port that returns read data in the ack cycle.
module vm_walker #(
    parameter int ADDR_W = 32,
    parameter int DIR_IDX_W = 10,
    parameter int TBL_IDX_W = 10,
    localparam int OFF_W = ADDR_W - DIR_IDX_W - TBL_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_cause,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [OFF_W-1:0]  rsp_attr,
    output logic [ADDR_W-1:0] rsp_vaddr,
    output logic              rsp_write,
    output logic              rsp_user
);
    import vm_walk_pkg::*;

    localparam int LEVELS = 2;

    logic [ADDR_W-1:0] pde_q, pte_q, va_q, base_q;
    logic              wr_q, usr_q;
    logic [ADDR_W-1:0] pde_addr, pte_addr, paddr_small, paddr_large;
    logic [ADDR_W-1:0] lvl_entry   [LEVELS];
    logic [ADDR_W-1:0] lvl_updated [LEVELS];
    logic [LEVELS-1:0] lvl_dirty, lvl_present, lvl_allow, lvl_changed;

    // Level 0 is the directory, level 1 the second-level table.
    always_comb begin
        lvl_entry[0] = pde_q;
        lvl_entry[1] = pte_q;
        lvl_dirty[0] = wr_q && pde_q[BIT_BIGPAGE];
        lvl_dirty[1] = wr_q;
    end

    for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
        vm_walk_perm #(.ADDR_W(ADDR_W)) u_perm (
            .entry    (lvl_entry[lvl]),
            .is_write (wr_q),
            .is_user  (usr_q),
            .set_dirty(lvl_dirty[lvl]),
            .present  (lvl_present[lvl]),
            .allow    (lvl_allow[lvl]),
            .changed  (lvl_changed[lvl]),
            .updated  (lvl_updated[lvl])
        );
    end

    vm_walk_addr #(
        .ADDR_W(ADDR_W), .DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W)
    ) u_addr (
        .vaddr      (va_q),
        .dir_base   (base_q),
        .pde_frame  (pde_q[ADDR_W-1:OFF_W]),
        .pte_frame  (pte_q[ADDR_W-1:OFF_W]),
        .pde_addr   (pde_addr),
        .pte_addr   (pte_addr),
        .paddr_small(paddr_small),
        .paddr_large(paddr_large)
    );

    vm_walk_seq #(.ADDR_W(ADDR_W), .ATTR_W(OFF_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .req_write  (req_write),
        .req_user   (req_user),
        .dir_base   (dir_base),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .pde_addr   (pde_addr),
        .pte_addr   (pte_addr),
        .paddr_small(paddr_small),
        .paddr_large(paddr_large),
        .dir_present(lvl_present[0]),
        .dir_allow  (lvl_allow[0]),
        .dir_changed(lvl_changed[0]),
        .dir_updated(lvl_updated[0]),
        .tbl_present(lvl_present[1]),
        .tbl_allow  (lvl_allow[1]),
        .tbl_changed(lvl_changed[1]),
        .tbl_updated(lvl_updated[1]),
        .pde_q      (pde_q),
        .pte_q      (pte_q),
        .va_q       (va_q),
        .wr_q       (wr_q),
        .usr_q      (usr_q),
        .base_q     (base_q),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_cause  (rsp_cause),
        .rsp_paddr  (rsp_paddr),
        .rsp_attr   (rsp_attr)
    );

    // Echo of the request that produced the current result.
    always_comb begin
        rsp_vaddr = va_q;
        rsp_write = wr_q;
        rsp_user = usr_q;
    end

endmodule

// File: rtl/vm_walker_chk.sv
// Module: protocol checker for the page walker, bound to the top module.
// Observes ports only; assumes synchronous active-low reset.
module vm_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              rsp_valid,
    input logic              rsp_fault
);
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));

    // R8
    wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[0] && mem_wdata[5]));

    // R9
    fault_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !$past(mem_req && mem_we));

endmodule

bind vm_walker vm_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault)
);

// File: tb/test_vm_walker.sv
// Scoreboard bench: the driver queues the expected result of each walk,
// the monitor pops and compares on every response pulse.
module test_vm_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dir_base = 32'h0000_1000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        rsp_valid, rsp_fault, rsp_cause, rsp_write, rsp_user;
    logic [31:0] rsp_paddr, rsp_vaddr;
    logic [11:0] rsp_attr;

    always #2.5 clk = ~clk;

    vm_walker i_vm_walker (
        .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr), .rsp_vaddr(rsp_vaddr),
        .rsp_write(rsp_write), .rsp_user(rsp_user)
    );

    // Word memory of 16 KB, optional alternate-cycle stall.
    logic [31:0] bmem [0:4095];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic        stall_en = 1'b0;
    logic        cyc = 1'b0;

    assign mem_ack = mem_req && !(stall_en && cyc);
    assign mem_rdata = bmem[mem_addr[13:2]];

    always @(posedge clk) begin
        cyc <= ~cyc;
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                bmem[mem_addr[13:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic        fault;
        logic        cause;
        logic [31:0] paddr;
        logic [11:0] attr;
        logic [31:0] nrd;
        logic [31:0] nwr;
        logic [31:0] base_rd;
        logic [31:0] base_wr;
    } exp_t;

    exp_t  expq [$];
    string tagq [$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Monitor: compare every response against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (expq.size() == 0) begin
                chk("R12 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk({t, " fault"}, {31'd0, rsp_fault}, {31'd0, e.fault});
                if (e.fault) chk({t, " cause"}, {31'd0, rsp_cause}, {31'd0, e.cause});
                chk({t, " paddr"}, rsp_paddr, e.paddr);
                chk({t, " attr"}, {20'd0, rsp_attr}, {20'd0, e.attr});
                chk({t, " R7 vaddr"}, rsp_vaddr, e.va);
                chk({t, " R7 write/user"}, {30'd0, rsp_write, rsp_user}, {30'd0, e.wr, e.usr});
                chk({t, " reads"}, rd_cnt - e.base_rd, e.nrd);
                chk({t, " R9 writes"}, wr_cnt - e.base_wr, e.nwr);
            end
        end
    end

    // Driver: queue the expectation, hand over the request, wait for result.
    task automatic walk(input string tag, input logic [31:0] va, input logic wr,
                        input logic usr, input logic fault, input logic cause,
                        input logic [31:0] paddr, input logic [11:0] attr,
                        input int nrd, input int nwr);
        exp_t e;
        e.va = va; e.wr = wr; e.usr = usr; e.fault = fault; e.cause = cause;
        e.paddr = fault ? 32'd0 : paddr;
        e.attr = fault ? 12'd0 : attr;
        e.nrd = nrd; e.nwr = nwr;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.base_rd = rd_cnt;
        e.base_wr = wr_cnt;
        expq.push_back(e);
        tagq.push_back(tag);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (expq.size() != 0) @(negedge clk);
    endtask

    task automatic mem_is(input string tag, input logic [31:0] addr, input logic [31:0] exp_v);
        @(negedge clk);
        chk(tag, bmem[addr[13:2]], exp_v);
    endtask

    function automatic logic [31:0] va_of(input int d, input int t, input int off);
        return {d[9:0], t[9:0], off[11:0]};
    endfunction

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) bmem[i] = 32'd0;
        // Directory at 0x1000, tables at 0x2000 and 0x3000.
        bmem[(32'h1004) >> 2] = 32'h0000_2007;
        bmem[(32'h2000 + 4*3) >> 2] = 32'h0ABC_D007;
        bmem[(32'h2000 + 4*5) >> 2] = 32'h0011_1005;
        bmem[(32'h100C) >> 2] = 32'h0000_3003;
        bmem[(32'h3000) >> 2] = 32'h0022_2007;
        bmem[(32'h1014) >> 2] = 32'h0400_0087;
        bmem[(32'h1018) >> 2] = 32'h0800_0085;
        bmem[(32'h101C) >> 2] = 32'h0C00_00E7;
        bmem[(32'h1FFC) >> 2] = 32'h0000_3007;
        bmem[(32'h3FFC) >> 2] = 32'hFFFF_F067;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // R2 R3 R8 first use: both entries gain the accessed flag
        walk("R3 small read", va_of(1, 3, 12'h123), 0, 1, 0, 0, 32'h0ABC_D123, 12'h027, 2, 2);
        mem_is("R8 pde accessed", 32'h1004, 32'h0000_2027);
        mem_is("R8 pte accessed", 32'h200C, 32'h0ABC_D027);
        // R9 flags already set: no write
        walk("R9 repeat read", va_of(1, 3, 12'hFFF), 0, 1, 0, 0, 32'h0ABC_DFFF, 12'h027, 2, 0);
        // R8 write sets dirty on the leaf only
        walk("R8 small write", va_of(1, 3, 12'h004), 1, 1, 0, 0, 32'h0ABC_D004, 12'h067, 2, 1);
        mem_is("R8 pte dirty", 32'h200C, 32'h0ABC_D067);
        // R4 absent at each level
        walk("R4 pte absent", va_of(1, 4, 12'h010), 1, 0, 1, 0, 0, 0, 2, 0);
        walk("R4 pde absent", va_of(2, 0, 12'h010), 0, 1, 1, 0, 0, 0, 1, 0);

        stall_en = 1'b1;
        // R5 write to read-only leaf, then a permitted read
        walk("R5 readonly write", va_of(1, 5, 12'hABC), 1, 1, 1, 1, 0, 0, 2, 0);
        mem_is("R9 no write on fault", 32'h2014, 32'h0011_1005);
        walk("R5 readonly read", va_of(1, 5, 12'hABC), 0, 1, 0, 0, 32'h0011_1ABC, 12'h025, 2, 1);
        // R6 absent leaf under a supervisor-only directory entry
        walk("R6 absent beats prot", va_of(3, 1, 12'h000), 0, 1, 1, 0, 0, 0, 2, 0);
        // R5 user blocked by the directory level
        walk("R5 user vs supervisor pde", va_of(3, 0, 12'h456), 0, 1, 1, 1, 0, 0, 2, 0);
        walk("R5 supervisor allowed", va_of(3, 0, 12'h456), 0, 0, 0, 0, 32'h0022_2456, 12'h027, 2, 2);
        mem_is("R9 pde written", 32'h100C, 32'h0000_3023);
        // R10 large pages
        walk("R10 big write", va_of(5, 0, 0) | 32'h0001_2345, 1, 1, 0, 0, 32'h0401_2345, 12'h0E7, 1, 1);
        mem_is("R10 big pde flags", 32'h1014, 32'h0400_00E7);
        walk("R10 big readonly write", va_of(6, 7, 12'h001), 1, 1, 1, 1, 0, 0, 1, 0);
        walk("R10 big read", va_of(6, 7, 12'h001), 0, 1, 0, 0, 32'h0800_7001, 12'h0A5, 1, 1);
        walk("R10 big flags set", 32'h01FF_FFFF, 1, 1, 0, 0, 32'h0C3F_FFFF, 12'h0E7, 1, 0);
        // R2 highest indices
        walk("R2 top indices", 32'hFFFF_FFFF, 0, 0, 0, 0, 32'hFFFF_FFFF, 12'h067, 2, 1);
        mem_is("R2 top pde", 32'h1FFC, 32'h0000_3027);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule